// File: doc/BRIEF.md
# SD Card Command Path Engine

This block is the command half of an SD/MMC host controller. Software loads a 32-bit argument and then writes a command word that carries a 6-bit command index, a response choice and an enable bit. The engine builds a 48-bit command frame, shifts it onto the card's CMD line one bit per card-clock tick, releases the line and, when a response is expected, waits for the card's start bit. It collects a 48-bit short response or a 136-bit long response and checks the CRC7. It then reports the outcome in sticky status flags, which software clears by writing ones.

The card-clock timing comes from outside. A one-cycle `card_tick` strobe in the system clock domain marks each card-clock edge on which the engine drives its next bit and samples `cmd_in`. There are five states. ST_IDLE waits for a command write with the enable bit set and then goes to ST_SEND. ST_SEND drives the 48 frame bits and releases the line on the following tick. From there it goes back to ST_IDLE when no response is wanted, or on to ST_WAIT. ST_WAIT samples the line until a start bit arrives, which leads to ST_RECV, or until the timeout runs out, which leads back to ST_IDLE. ST_RECV collects the rest of the response and then goes to ST_CHECK. ST_CHECK compares the CRC, loads the response registers, raises the result flag and returns to ST_IDLE. A command write with the enable bit clear, made while busy, takes ST_SEND, ST_WAIT or ST_RECV straight back to ST_IDLE.

Register word addresses on `reg_addr`: 0 argument, 1 command, 2 status (read), 3 clear (write), 4 response index, 5 to 8 response words 0 to 3.

Top module: `sd_cmd_engine`

## Requirements
- R1: Command register fields: index in bits 5:0, response-expected in bit 6, long response in bit 7 (only together with bit 6), enable in bit 10. A write with bit 10 set while idle starts one command. The argument and command registers read back the values written.
- R2: The frame is sent MSB first, one bit per `card_tick`: start 0, transmission 1, index, argument, CRC7 (x^7+x^3+1) over the first 40 bits, end 1. `cmd_oe` is high for exactly those 48 ticks.
- R3: Command bits 8 and 9 are stored and read back but do not change the frame or the outcome.
- R4: Status bit 11 (active) is high from the starting write until the command finishes, and low otherwise.
- R5: With no response requested, status bit 7 (sent) is set on the tick after the end bit.
- R6: A short response (start 0, transmission 0, index, 32-bit card status, CRC7, end 1) with a correct CRC7 sets status bit 6 (response end). It puts the card status in response word 0 and the index field in the response index register.
- R7: A response whose CRC7 does not match sets status bit 0 (CRC fail) and leaves bit 6 clear.
- R8: When `cmd_in` is sampled high on 64 consecutive ticks after the line is released, status bit 2 (timeout) is set. A start bit on the 64th tick still starts reception.
- R9: A long response has 136 bits. Its CRC7 covers field bits 127:8 and is compared with field bits 7:1. Field bits 127:0 fill words 0 to 3, with word 0 the most significant, and the 6-bit header lands in the response index register.
- R10: Status bits 10:0 are sticky. A write to the clear register clears the flags where its data bits are 1. An event in the same cycle wins.
- R11: A command write with bit 10 clear during a busy command aborts it. The line is released, active drops and no result flag is set.
- R12: After reset the status, response and index registers read 0 and `cmd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| card_tick | input | 1 | One-cycle strobe per card-clock bit slot |
| cmd_in | input | 1 | CMD line as seen from the card |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |

## Verification
Embedded properties check on every cycle that the line is driven only in ST_SEND and that at most one result event fires per command end. They also check that the wait counter never reaches its limit inside ST_WAIT, that a start or an abort moves the state machine on in the next cycle, and that sticky flags only fall under a matching clear. Whether the bits on `cmd_out` and the CRC7 values are correct can only be shown by the directed scenarios, which compare against frames built independently in the bench. The same holds for the response word layout, the exact 64-tick timeout boundary and the inertness of bits 8 and 9.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_CHECK
    } cmd_state_t;

    // register word addresses
    localparam logic [3:0] A_ARG    = 4'd0;
    localparam logic [3:0] A_CMD    = 4'd1;
    localparam logic [3:0] A_STATUS = 4'd2;
    localparam logic [3:0] A_CLEAR  = 4'd3;
    localparam logic [3:0] A_RIDX   = 4'd4;
    localparam logic [3:0] A_RESP0  = 4'd5;

    // command register bit positions
    localparam int C_RESP   = 6;
    localparam int C_LONG   = 7;
    localparam int C_ENABLE = 10;

    // status bit positions
    localparam int S_CRCFAIL = 0;
    localparam int S_TMO     = 2;
    localparam int S_REND    = 6;
    localparam int S_SENT    = 7;
    localparam int S_ACTIVE  = 11;
    localparam int FLAG_W    = 11;

    // frame geometry
    localparam int TX_BITS    = 48;
    localparam int TX_CRC_LO  = 40;
    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int RX_W       = 134;

endpackage

// File: rtl/sd_crc7.sv
module sd_crc7 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);

    logic fb;
    assign fb = din ^ crc[6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
    end

endmodule

// File: rtl/sd_cmd_regs.sv
module sd_cmd_regs
    import sd_cmd_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4,
    parameter int NWORDS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    input  logic                busy,
    input  logic                ev_sent,
    input  logic                ev_rend,
    input  logic                ev_crc,
    input  logic                ev_tmo,
    input  logic                resp_load,
    input  logic                resp_long,
    input  logic [NWORDS*DW-1:0] resp_words,
    input  logic [5:0]          resp_idx,
    output logic [DW-1:0]       arg,
    output logic                start,
    output logic                abort,
    output logic [5:0]          start_idx,
    output logic                start_resp,
    output logic                start_long
);

    localparam int CMD_W = C_ENABLE + 1;

    logic [DW-1:0]     arg_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [FLAG_W-1:0] flags_q;
    logic [5:0]        ridx_q;
    logic [DW-1:0]     resp_q [NWORDS];
    logic              wr_cmd;
    logic [FLAG_W-1:0] clr_mask;
    logic [FLAG_W-1:0] set_mask;

    assign wr_cmd     = wr && (addr == AW'(A_CMD));
    assign start      = wr_cmd && wdata[C_ENABLE] && !busy;
    assign abort      = wr_cmd && !wdata[C_ENABLE] && busy;
    assign start_idx  = wdata[5:0];
    assign start_resp = wdata[C_RESP];
    assign start_long = wdata[C_RESP] && wdata[C_LONG];
    assign arg        = arg_q;

    assign clr_mask = (wr && addr == AW'(A_CLEAR)) ? wdata[FLAG_W-1:0] : '0;

    always_comb begin
        set_mask            = '0;
        set_mask[S_SENT]    = ev_sent;
        set_mask[S_REND]    = ev_rend;
        set_mask[S_CRCFAIL] = ev_crc;
        set_mask[S_TMO]     = ev_tmo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q   <= '0;
            cmd_q   <= '0;
            flags_q <= '0;
            ridx_q  <= '0;
        end else begin
            if (wr && addr == AW'(A_ARG)) arg_q <= wdata;
            if (wr_cmd) cmd_q <= wdata[CMD_W-1:0];
            flags_q <= (flags_q & ~clr_mask) | set_mask;
            if (resp_load) ridx_q <= resp_idx;
        end
    end

    // word 0 takes the most significant slice; other words only on long responses
    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_resp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    resp_q[w] <= '0;
                end else if (resp_load && (w == 0 || resp_long)) begin
                    resp_q[w] <= resp_words[(NWORDS-w)*DW-1 -: DW];
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        unique case (addr)
            AW'(A_ARG):    rdata = arg_q;
            AW'(A_CMD):    rdata = DW'(cmd_q);
            AW'(A_STATUS): rdata = DW'({busy, flags_q});
            AW'(A_RIDX):   rdata = DW'(ridx_q);
            AW'(A_RESP0):  rdata = resp_q[0];
            AW'(A_RESP0 + 4'd1): rdata = resp_q[1];
            AW'(A_RESP0 + 4'd2): rdata = resp_q[2];
            AW'(A_RESP0 + 4'd3): rdata = resp_q[3];
            default:       rdata = '0;
        endcase
    end

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(flags_q) & ~$past(clr_mask)) & ~flags_q) == '0));

    // R10
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tmo || ev_crc) |=> (flags_q[S_TMO] || flags_q[S_CRCFAIL]));

endmodule

// File: rtl/sd_cmd_fsm.sv
module sd_cmd_fsm
    import sd_cmd_pkg::*;
#(
    parameter int DW = 32,
    parameter int TIMEOUT_TICKS = 64,
    localparam int TW = $clog2(TIMEOUT_TICKS + 1),
    localparam int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            abort,
    input  logic [5:0]      start_idx,
    input  logic            start_resp,
    input  logic            start_long,
    input  logic [DW-1:0]   arg,
    input  logic            tick,
    input  logic            cmd_in,
    input  logic [6:0]      crc,
    output logic            crc_clr,
    output logic            crc_en,
    output logic            crc_din,
    output logic            cmd_out,
    output logic            cmd_oe,
    output logic            busy,
    output logic            ev_sent,
    output logic            ev_rend,
    output logic            ev_crc,
    output logic            ev_tmo,
    output logic            resp_load,
    output logic            resp_long,
    output logic [4*DW-1:0] resp_words,
    output logic [5:0]      resp_idx
);

    cmd_state_t       state, nxt;
    logic [TX_BITS-1:0] tx_sh;
    logic [RX_W-1:0]  rx_sh;
    logic [CW-1:0]    bit_cnt;
    logic [TW-1:0]    wait_cnt;
    logic             want_resp, want_long;
    logic             out_q, oe_q;
    logic             tx_bit, tx_last, tmo_hit, rx_last, crc_ok;
    logic [CW-1:0]    crc_off;
    logic [CW-1:0]    rx_len;

    assign rx_len  = want_long ? CW'(LONG_BITS) : CW'(SHORT_BITS);
    assign crc_off = CW'(TX_BITS - 2) - bit_cnt;
    assign tx_bit  = (bit_cnt >= CW'(TX_CRC_LO) && bit_cnt < CW'(TX_BITS - 1))
                     ? crc[crc_off[2:0]] : tx_sh[TX_BITS-1];
    assign tx_last = tick && bit_cnt == CW'(TX_BITS);
    assign tmo_hit = tick && cmd_in && wait_cnt == TW'(TIMEOUT_TICKS - 1);
    assign rx_last = tick && bit_cnt == rx_len - CW'(1);
    assign crc_ok  = crc == rx_sh[7:1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_SEND;
            ST_SEND:  if (abort) nxt = ST_IDLE;
                      else if (tx_last) nxt = want_resp ? ST_WAIT : ST_IDLE;
            ST_WAIT:  if (abort) nxt = ST_IDLE;
                      else if (tick && !cmd_in) nxt = ST_RECV;
                      else if (tmo_hit) nxt = ST_IDLE;
            ST_RECV:  if (abort) nxt = ST_IDLE;
                      else if (rx_last) nxt = ST_CHECK;
            ST_CHECK: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh     <= '0;
            rx_sh     <= '0;
            bit_cnt   <= '0;
            wait_cnt  <= '0;
            want_resp <= 1'b0;
            want_long <= 1'b0;
            out_q     <= 1'b1;
            oe_q      <= 1'b0;
        end else if (abort && state != ST_IDLE) begin
            out_q <= 1'b1;
            oe_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    tx_sh     <= {1'b0, 1'b1, start_idx, arg, 7'h00, 1'b1};
                    bit_cnt   <= '0;
                    want_resp <= start_resp;
                    want_long <= start_long;
                end
                ST_SEND: if (tick) begin
                    if (bit_cnt < CW'(TX_BITS)) begin
                        out_q   <= tx_bit;
                        oe_q    <= 1'b1;
                        tx_sh   <= {tx_sh[TX_BITS-2:0], 1'b0};
                        bit_cnt <= bit_cnt + CW'(1);
                    end else begin
                        out_q    <= 1'b1;
                        oe_q     <= 1'b0;
                        wait_cnt <= '0;
                        rx_sh    <= '0;
                    end
                end
                ST_WAIT: if (tick) begin
                    if (!cmd_in) begin
                        rx_sh   <= {rx_sh[RX_W-2:0], 1'b0};
                        bit_cnt <= CW'(1);
                    end else begin
                        wait_cnt <= wait_cnt + TW'(1);
                    end
                end
                ST_RECV: if (tick) begin
                    rx_sh   <= {rx_sh[RX_W-2:0], cmd_in};
                    bit_cnt <= bit_cnt + CW'(1);
                end
                ST_CHECK: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = state != ST_IDLE;
        cmd_out   = out_q;
        cmd_oe    = oe_q;
        ev_sent   = (state == ST_SEND) && tx_last && !want_resp && !abort;
        ev_tmo    = (state == ST_WAIT) && tmo_hit && !abort;
        ev_rend   = (state == ST_CHECK) && crc_ok;
        ev_crc    = (state == ST_CHECK) && !crc_ok;
        resp_load = state == ST_CHECK;
        resp_long = want_long;
        resp_words = want_long ? rx_sh[127:0] : {rx_sh[39:8], 96'h0};
        resp_idx  = want_long ? rx_sh[133:128] : rx_sh[45:40];
        crc_clr   = ((state == ST_IDLE) && start) || ((state == ST_SEND) && tx_last);
        crc_en    = 1'b0;
        crc_din   = 1'b0;
        unique case (state)
            ST_SEND: begin
                crc_en  = tick && bit_cnt < CW'(TX_CRC_LO);
                crc_din = tx_sh[TX_BITS-1];
            end
            ST_WAIT: begin
                crc_en  = tick && !cmd_in && !want_long;
                crc_din = 1'b0;
            end
            ST_RECV: begin
                crc_en  = tick && (want_long ? (bit_cnt >= CW'(8) && bit_cnt < CW'(128))
                                             : (bit_cnt < CW'(TX_CRC_LO)));
                crc_din = cmd_in;
            end
            default: ;
        endcase
    end

    // R2
    drive_only_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> state == ST_SEND);

    // R5
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_sent, ev_rend, ev_crc, ev_tmo}));

    // R8
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WAIT |-> wait_cnt < TW'(TIMEOUT_TICKS));

    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> (!busy && !cmd_oe));

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4,
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          card_tick,
    input  logic          cmd_in,
    output logic          cmd_out,
    output logic          cmd_oe
);

    logic [DW-1:0]   arg;
    logic            start, abort, start_resp, start_long;
    logic [5:0]      start_idx;
    logic            busy, ev_sent, ev_rend, ev_crc, ev_tmo;
    logic            resp_load, resp_long;
    logic [4*DW-1:0] resp_words;
    logic [5:0]      resp_idx;
    logic            crc_clr, crc_en, crc_din;
    logic [6:0]      crc;

    sd_cmd_regs #(.DW(DW), .AW(AW), .NWORDS(4)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .busy(busy),
        .ev_sent(ev_sent), .ev_rend(ev_rend), .ev_crc(ev_crc), .ev_tmo(ev_tmo),
        .resp_load(resp_load), .resp_long(resp_long),
        .resp_words(resp_words), .resp_idx(resp_idx),
        .arg(arg), .start(start), .abort(abort),
        .start_idx(start_idx), .start_resp(start_resp), .start_long(start_long)
    );

    sd_cmd_fsm #(.DW(DW), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(start), .abort(abort),
        .start_idx(start_idx), .start_resp(start_resp), .start_long(start_long),
        .arg(arg), .tick(card_tick), .cmd_in(cmd_in), .crc(crc),
        .crc_clr(crc_clr), .crc_en(crc_en), .crc_din(crc_din),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy),
        .ev_sent(ev_sent), .ev_rend(ev_rend), .ev_crc(ev_crc), .ev_tmo(ev_tmo),
        .resp_load(resp_load), .resp_long(resp_long),
        .resp_words(resp_words), .resp_idx(resp_idx)
    );

    sd_crc7 u_crc (
        .clk(clk), .rst_n(rst_n),
        .clr(crc_clr), .en(crc_en), .din(crc_din), .crc(crc)
    );

endmodule

// File: tb/sim_sd_cmd_engine.sv
module sim_sd_cmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        card_tick = 1'b0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe;

    int checks = 0;
    int errors = 0;
    logic last_out, last_oe;
    int   oe_count;

    always #5 clk = ~clk;

    sd_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_tick(card_tick),
        .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7(input logic [135:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic f = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (f) c = c ^ 7'h09;
        end
        return c;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick(input logic din);
        @(negedge clk);
        cmd_in = din; card_tick = 1'b1;
        @(negedge clk);
        card_tick = 1'b0;
        last_out = cmd_out; last_oe = cmd_oe;
        if (cmd_oe) oe_count++;
        @(negedge clk);
        @(negedge clk);
    endtask

    // capture the 48 driven bits plus the release tick
    task automatic grab_frame(output logic [47:0] f, output logic rel_oe);
        oe_count = 0;
        for (int i = 0; i < 48; i++) begin
            tick(1'b1);
            f = {f[46:0], last_out};
        end
        tick(1'b1);
        rel_oe = last_oe;
    endtask

    function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] a);
        logic [39:0] h = {2'b01, idx, a};
        return {h, crc7({96'h0, h}, 40), 1'b1};
    endfunction

    task automatic send_bits(input logic [135:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) tick(v[i]);
        cmd_in = 1'b1;
    endtask

    task automatic short_resp(input logic [5:0] idx, input logic [31:0] st, input logic bad);
        logic [39:0] h = {2'b00, idx, st};
        logic [6:0]  c = crc7({96'h0, h}, 40) ^ (bad ? 7'h01 : 7'h00);
        send_bits({88'h0, h, c, 1'b1}, 48);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'd2, d); check("R12", "status", d, 0);
        rd(4'd5, d); check("R12", "resp0", d, 0);
        rd(4'd4, d); check("R12", "ridx", d, 0);
        check("R12", "oe", cmd_oe, 0);
    endtask

    task automatic t_noresp;
        logic [47:0] f; logic rel; logic [31:0] d;
        check("R2", "crc7 self", cmd_frame(6'd8, 32'h1AA), 48'h48000001AA87);
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h400);
        rd(4'd2, d); check("R4", "active during send", d[11], 1);
        grab_frame(f, rel);
        check("R2", "cmd0 frame", f, 48'h400000000095);
        check("R2", "oe ticks", oe_count, 48);
        check("R2", "released", rel, 0);
        rd(4'd2, d);
        check("R5", "sent flag", d[7], 1);
        check("R4", "active after", d[11], 0);
        wr(4'd1, 32'h0);
        wr(4'd3, 32'h7FF);
    endtask

    task automatic t_short_ok;
        logic [47:0] f; logic rel; logic [31:0] d;
        wr(4'd0, 32'h1AA);
        wr(4'd1, 32'h448);
        rd(4'd0, d); check("R1", "arg readback", d, 32'h1AA);
        rd(4'd1, d); check("R1", "cmd readback", d, 32'h448);
        grab_frame(f, rel);
        check("R2", "cmd8 frame", f, 48'h48000001AA87);
        for (int i = 0; i < 5; i++) tick(1'b1);
        rd(4'd2, d); check("R4", "active waiting", d[11], 1);
        short_resp(6'd8, 32'h0000_01AA, 1'b0);
        rd(4'd2, d);
        check("R6", "resp end", d[6], 1);
        check("R7", "no crc fail", d[0], 0);
        check("R4", "idle", d[11], 0);
        rd(4'd5, d); check("R6", "resp0", d, 32'h1AA);
        rd(4'd4, d); check("R6", "ridx", d, 8);
        wr(4'd1, 32'h0); wr(4'd3, 32'h7FF);
    endtask

    task automatic t_short_bad;
        logic [47:0] f; logic rel; logic [31:0] d;
        wr(4'd0, 32'hDEAD_0001);
        wr(4'd1, 32'h44D);
        grab_frame(f, rel);
        short_resp(6'd13, 32'h0000_0900, 1'b1);
        rd(4'd2, d);
        check("R7", "crc fail", d[0], 1);
        check("R7", "resp end clear", d[6], 0);
        wr(4'd1, 32'h0); wr(4'd3, 32'h7FF);
    endtask

    task automatic t_timeout;
        logic [47:0] f; logic rel; logic [31:0] d;
        wr(4'd1, 32'h451);
        grab_frame(f, rel);
        for (int i = 0; i < 63; i++) tick(1'b1);
        rd(4'd2, d); check("R8", "no timeout at 63", d[2], 0);
        tick(1'b1);
        rd(4'd2, d);
        check("R8", "timeout at 64", d[2], 1);
        check("R8", "idle after timeout", d[11], 0);
        // R10: sticky across a second command; last-tick start bit accepted (R8)
        wr(4'd1, 32'h0);
        wr(4'd1, 32'h451);
        grab_frame(f, rel);
        for (int i = 0; i < 63; i++) tick(1'b1);
        short_resp(6'd17, 32'hCAFE_F00D, 1'b0);
        rd(4'd2, d);
        check("R8", "start on 64th tick", d[6], 1);
        check("R10", "timeout sticky", d[2], 1);
        wr(4'd3, 32'h040);
        rd(4'd2, d);
        check("R10", "partial clear", d[11:0], 12'h004);
        wr(4'd3, 32'h7FF);
        rd(4'd2, d);
        check("R10", "full clear", d, 0);
        wr(4'd1, 32'h0);
    endtask

    task automatic t_long;
        logic [47:0] f; logic [127:0] fld; logic [135:0] v; logic rel; logic [31:0] d;
        fld = {120'h1B534D_5342_4E52_5500_1234_5678_9ABC, 8'h00};
        fld[7:1] = crc7({16'h0, fld[127:8]}, 120);
        fld[0] = 1'b1;
        v = {2'b00, 6'h3F, fld};
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h4C2);
        grab_frame(f, rel);
        check("R9", "cmd2 frame", f, cmd_frame(6'd2, 32'h0));
        tick(1'b1); tick(1'b1);
        send_bits(v, 136);
        rd(4'd2, d); check("R9", "resp end", d[6], 1);
        check("R9", "no crc fail", d[0], 0);
        rd(4'd5, d); check("R9", "word0", d, fld[127:96]);
        rd(4'd6, d); check("R9", "word1", d, fld[95:64]);
        rd(4'd7, d); check("R9", "word2", d, fld[63:32]);
        rd(4'd8, d); check("R9", "word3", d, fld[31:0]);
        rd(4'd4, d); check("R9", "ridx header", d, 6'h3F);
        wr(4'd1, 32'h0); wr(4'd3, 32'h7FF);
    endtask

    task automatic t_bits89;
        logic [47:0] f; logic rel; logic [31:0] d;
        wr(4'd0, 32'h0055_AA00);
        wr(4'd1, 32'h707);
        rd(4'd1, d); check("R3", "readback 8/9", d, 32'h707);
        grab_frame(f, rel);
        check("R3", "frame unchanged", f, cmd_frame(6'd7, 32'h0055_AA00));
        rd(4'd2, d); check("R3", "sent as plain", d[7], 1);
        wr(4'd1, 32'h0); wr(4'd3, 32'h7FF);
    endtask

    task automatic t_abort;
        logic [31:0] d;
        wr(4'd1, 32'h449);
        for (int i = 0; i < 10; i++) tick(1'b1);
        check("R11", "driving before abort", last_oe, 1);
        wr(4'd1, 32'h049);
        rd(4'd2, d); check("R11", "active dropped", d[11], 0);
        check("R11", "line released", cmd_oe, 0);
        for (int i = 0; i < 70; i++) tick(1'b1);
        rd(4'd2, d); check("R11", "no flags", d, 0);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_noresp;
        t_short_ok;
        t_short_bad;
        t_timeout;
        t_long;
        t_bits89;
        t_abort;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule